// File: doc/BRIEF.md
# Descriptor-Chained DMA Transfer Engine

This block is a single DMA channel sequencer. It reads a four-word descriptor from memory, moves data from a source address to a target address in bursts, and counts a byte length down to zero. When the length reaches zero it either stops or loads the next descriptor in a linked list. All memory traffic goes through one word-addressed request port with per-byte lane enables.

Software, or a neighbouring block, can load the descriptor pointer and the working registers directly while the channel is idle. Pulsing `go` then starts the channel. In fetch mode the first descriptor is loaded from the pointer. In no-fetch mode the channel runs straight from the loaded registers. A level `flow_req` from a peripheral paces flow-controlled transfers. Single-cycle event outputs mark these points:
- the descriptor start;
- the transfer end;
- the channel stop;
- an end-of-receive, which happens when a flow-controlled request goes away.

The memory port is a request/acknowledge stream. The engine raises `mem_req` together with address, direction, lane enables and write data. It must hold all of these stable until it samples `mem_ack` high at a clock edge. The memory applies back-pressure simply by holding `mem_ack` low. Read data is taken in the cycle that `mem_ack` is high. The engine may present its next access in the cycle right after an acknowledge.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, `busy` is low, `mem_req` is low and no event output is asserted.
- R2: In fetch mode, `go` reads four words in order: next pointer, source, target and command. The byte addresses are base, base+4, base+8 and base+12. The base is the pointer with its low four bits cleared.
- R3: If pointer bit 1 (branch) is set and `cmp_flag` is high, the descriptor is read from the base plus 32 bytes instead.
- R4: The command word is laid out as follows:
  - bits 12:0 hold the remaining length in bytes;
  - bits 15:14 give the beat width: 1 selects 1 byte, 2 selects 2 bytes, 0 or 3 select 4 bytes;
  - bits 17:16 give the burst size, 4 bytes shifted left by the field;
  - bit 31 makes the source advance by one width per beat, and bit 30 does the same for the target.
- R5: Each burst moves the smaller of the length and the burst size. It performs all reads first, then all writes. A beat at byte address A uses lanes A[1:0] upward. Lanes outside the beat are left untouched in memory.
- R6: A descriptor whose command bit 22 is set pulses `ev_start` once the fetch completes. Command bit 21 pulses `ev_end` when the length reaches zero.
- R7: At length zero the channel stops if any of these holds: `nofetch` is set, pointer bit 0 (stop) is set, or `eor_stop_en` is set. Stopping pulses `ev_stop` and drops `busy`. Otherwise the channel fetches the descriptor that the next-pointer word names.
- R8: Command bit 29 marks the source as flow-controlled and bit 28 the target. The matching address loses its low two bits when the descriptor is fetched. A burst of a flow-controlled transfer starts only while `flow_req` is high.
- R9: If `flow_req` is low after a flow-controlled burst, `ev_eor` pulses. The channel then does one of the following:
  - it stops if `eor_stop_en` is set;
  - otherwise it fetches the next descriptor if `eor_jump_en` is set and `nofetch` is clear;
  - otherwise it continues with the normal length handling.
- R10: A `cfg_we` write selects a register with `cfg_sel`: 0 is the pointer, 1 the source, 2 the target and 3 the command. The write takes effect while idle and is ignored while `busy` is high.
- R11: While `mem_req` is high and not yet acknowledged, the address and direction stay unchanged in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start strobe, honoured while idle |
| nofetch | input | 1 | Run from loaded registers; stop at length zero |
| eor_stop_en | input | 1 | Stop on end-of-receive or at length zero |
| eor_jump_en | input | 1 | Fetch next descriptor on end-of-receive |
| cmp_flag | input | 1 | Compare status used by the branch bit |
| flow_req | input | 1 | Peripheral request level for flow control |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 pointer, 1 source, 2 target, 3 command) |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW-2 | Word address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory accepts/completes the access |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Channel running |
| ev_start | output | 1 | Descriptor start event pulse |
| ev_end | output | 1 | Transfer end event pulse |
| ev_stop | output | 1 | Channel stop event pulse |
| ev_eor | output | 1 | End-of-receive event pulse |

## Verification
A corrupted length or beat counter shows up as extra or missing write accesses. It also shows up in target memory words that differ from the source pattern. Both are visible within the burst where the fault occurs. A wrong fetch pointer or a lost branch decision appears in the word addresses of the very next four reads after `go` or after a chain step. A lane mistake appears as damaged neighbour bytes in a partially written word. A flow-control fault appears as a write on the memory port while `flow_req` is low, or as a missing `ev_eor` pulse two cycles after the final write of a burst is acknowledged.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 13;
  localparam int BURST_MAX = 32;

  localparam int B_INC_SRC = 31;
  localparam int B_INC_DST = 30;
  localparam int B_FLOW_S  = 29;
  localparam int B_FLOW_T  = 28;
  localparam int B_IRQ_ST  = 22;
  localparam int B_IRQ_END = 21;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_READ, ST_WRITE, ST_DECIDE
  } dma_state_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [2:0]       wbytes;
    logic [5:0]       bbytes;
    logic             inc_src;
    logic             inc_dst;
    logic             flow_src;
    logic             flow_dst;
    logic             end_en;
  } cmd_fields_t;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_chain_pkg::*;
(
  input  logic [WORD_W-1:0] cmd,
  output cmd_fields_t       fld
);
  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd[27:22], cmd[20:18], cmd[13]};

  always_comb begin
    fld.len      = cmd[LEN_W-1:0];
    unique case (cmd[15:14])
      2'd1:    fld.wbytes = 3'd1;
      2'd2:    fld.wbytes = 3'd2;
      default: fld.wbytes = 3'd4;
    endcase
    fld.bbytes   = 6'd4 << cmd[17:16];
    fld.inc_src  = cmd[B_INC_SRC];
    fld.inc_dst  = cmd[B_INC_DST];
    fld.flow_src = cmd[B_FLOW_S];
    fld.flow_dst = cmd[B_FLOW_T];
    fld.end_en   = cmd[B_IRQ_END];
  end
endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
  parameter  int MAXB = 32,
  localparam int OW   = $clog2(MAXB) + 1
) (
  input  logic          clk,
  input  logic          put_en,
  input  logic [OW-1:0] put_off,
  input  logic [1:0]    put_lane,
  input  logic [2:0]    put_w,
  input  logic [31:0]   put_word,
  input  logic [OW-1:0] get_off,
  input  logic [1:0]    get_lane,
  input  logic [2:0]    get_w,
  output logic [31:0]   get_word,
  output logic [3:0]    get_be
);
  logic [7:0]    store [MAXB];
  logic [7:0]    pbyte [4];
  logic [OW-1:0] pidx  [4];
  logic          pok   [4];
  logic [1:0]    gln   [4];
  logic [OW-1:0] gidx  [4];

  // byte k of a beat comes from lane (lane+k) of the bus word
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      pbyte[k] = put_word[{2'(put_lane + 2'(k)), 3'b000} +: 8];
      pidx[k]  = put_off + OW'(k);
      pok[k]   = (3'(k) < put_w) && (pidx[k] < OW'(MAXB));
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (put_en && pok[k]) store[pidx[k][OW-2:0]] <= pbyte[k];
  end

  always_comb begin
    get_word = '0;
    get_be   = '0;
    for (int k = 0; k < 4; k++) begin
      gln[k]  = get_lane + 2'(k);
      gidx[k] = get_off + OW'(k);
      if (3'(k) < get_w) begin
        get_word[{gln[k], 3'b000} +: 8] =
          (gidx[k] < OW'(MAXB)) ? store[gidx[k][OW-2:0]] : 8'h00;
        get_be[gln[k]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          nofetch,
  input  logic          eor_stop_en,
  input  logic          eor_jump_en,
  input  logic          cmp_flag,
  input  logic          flow_req,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-3:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          ev_start,
  output logic          ev_end,
  output logic          ev_stop,
  output logic          ev_eor
);
  localparam int OW = $clog2(BURST_MAX) + 1;

  dma_state_e    st;
  logic [31:0]   r_desc, r_src, r_dst, r_cmd;
  logic [AW-1:0] fptr;
  logic [1:0]    fidx;
  logic [OW-1:0] chunk, cnt, chunk_n;
  cmd_fields_t   f;
  logic          flowctl, last_beat, eor_now;
  logic [3:0]    rd_be, wr_be;
  logic [31:0]   wr_word;
  logic          unused_desc;

  assign unused_desc = ^r_desc[3:2];

  dma_cmd_decode u_dec (.cmd(r_cmd), .fld(f));

  dma_burst_buf #(.MAXB(BURST_MAX)) u_buf (
    .clk(clk),
    .put_en(st == ST_READ && mem_ack), .put_off(cnt),
    .put_lane(r_src[1:0]), .put_w(f.wbytes), .put_word(mem_rdata),
    .get_off(cnt), .get_lane(r_dst[1:0]), .get_w(f.wbytes),
    .get_word(wr_word), .get_be(wr_be)
  );

  function automatic logic [AW-1:0] fetch_base(input logic [31:0] d, input logic c);
    return {d[AW-1:4], 4'b0000} + ((d[1] && c) ? AW'(32) : AW'(0));
  endfunction

  assign flowctl   = f.flow_src | f.flow_dst;
  assign eor_now   = flowctl && !flow_req;
  assign chunk_n   = (f.len < {7'b0, f.bbytes}) ? f.len[OW-1:0] : f.bbytes;
  assign last_beat = ({1'b0, cnt} + (OW+1)'(f.wbytes)) >= {1'b0, chunk};
  assign rd_be     = 4'((4'b1111 >> (3'd4 - f.wbytes)) << r_src[1:0]);
  assign busy      = (st != ST_IDLE);

  always_comb begin
    mem_req   = (st == ST_FETCH) || (st == ST_READ) || (st == ST_WRITE);
    mem_we    = (st == ST_WRITE);
    mem_wdata = wr_word;
    unique case (st)
      ST_FETCH: begin mem_addr = fptr[AW-1:2];  mem_be = 4'hF;  end
      ST_READ:  begin mem_addr = r_src[AW-1:2]; mem_be = rd_be; end
      ST_WRITE: begin mem_addr = r_dst[AW-1:2]; mem_be = wr_be; end
      default:  begin mem_addr = '0;            mem_be = 4'h0;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      r_desc <= '0; r_src <= '0; r_dst <= '0; r_cmd <= '0;
      fptr <= '0; fidx <= '0; chunk <= '0; cnt <= '0;
      ev_start <= 1'b0; ev_end <= 1'b0; ev_stop <= 1'b0; ev_eor <= 1'b0;
    end else begin
      ev_start <= 1'b0; ev_end <= 1'b0; ev_stop <= 1'b0; ev_eor <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (cfg_we) begin
            unique case (cfg_sel)
              2'd0: r_desc <= cfg_wdata;
              2'd1: r_src  <= cfg_wdata;
              2'd2: r_dst  <= cfg_wdata;
              default: r_cmd <= cfg_wdata;
            endcase
          end
          if (go) begin
            fptr <= fetch_base(r_desc, cmp_flag);
            fidx <= '0;
            st   <= nofetch ? ST_WAIT : ST_FETCH;
          end
        end
        ST_FETCH: if (mem_ack) begin
          fptr <= fptr + AW'(4);
          fidx <= fidx + 2'd1;
          unique case (fidx)
            2'd0: r_desc <= mem_rdata;
            2'd1: r_src  <= mem_rdata;
            2'd2: r_dst  <= mem_rdata;
            default: begin
              r_cmd <= mem_rdata;
              if (mem_rdata[B_FLOW_S]) r_src[1:0] <= 2'b00;
              if (mem_rdata[B_FLOW_T]) r_dst[1:0] <= 2'b00;
              ev_start <= mem_rdata[B_IRQ_ST];
              st <= ST_WAIT;
            end
          endcase
        end
        ST_WAIT: begin
          if (f.len == '0) st <= ST_DECIDE;
          else if (!flowctl || flow_req) begin
            chunk <= chunk_n;
            cnt   <= '0;
            st    <= ST_READ;
          end
        end
        ST_READ: if (mem_ack) begin
          if (f.inc_src) r_src <= r_src + 32'(f.wbytes);
          cnt <= last_beat ? '0 : cnt + OW'(f.wbytes);
          if (last_beat) st <= ST_WRITE;
        end
        ST_WRITE: if (mem_ack) begin
          if (f.inc_dst) r_dst <= r_dst + 32'(f.wbytes);
          cnt <= cnt + OW'(f.wbytes);
          if (last_beat) begin
            r_cmd[LEN_W-1:0] <= f.len - {7'b0, chunk};
            st <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (eor_now) ev_eor <= 1'b1;
          if (eor_now && eor_stop_en) begin
            ev_stop <= 1'b1;
            st <= ST_IDLE;
          end else if (eor_now && eor_jump_en && !nofetch) begin
            fptr <= fetch_base(r_desc, cmp_flag);
            fidx <= '0;
            st   <= ST_FETCH;
          end else if (f.len == '0) begin
            ev_end <= f.end_en;
            if (nofetch || r_desc[0] || eor_stop_en) begin
              ev_stop <= 1'b1;
              st <= ST_IDLE;
            end else begin
              fptr <= fetch_base(r_desc, cmp_flag);
              fidx <= '0;
              st   <= ST_FETCH;
            end
          end else st <= ST_WAIT;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11: pending access fields held until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R1: an idle channel issues no memory traffic
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  // R7: the stop event coincides with the idle state
  a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |-> !busy);
  // R8: a flow-controlled burst begins only with the request present
  a_r8_flow_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && $past(st) == ST_WAIT && $past(flowctl)) |-> $past(flow_req));
  // R5: every write beat enables at least one lane
  a_r5_write_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 4'h0));
  // R6: the start event only appears on a running channel
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> busy);
endmodule

// File: tb/dma_chain_engine_test.sv
module dma_chain_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 0, nofetch = 0, eor_stop_en = 0, eor_jump_en = 0, cmp_flag = 0, flow_req = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic mem_req, mem_we, mem_ack;
  logic [29:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic busy, ev_start, ev_end, ev_stop, ev_eor;

  always #5 clk = ~clk;

  dma_chain_engine uut (.*);

  // memory model
  logic [31:0] mem [0:1023];
  logic [29:0] lg_addr [0:255];
  logic        lg_we   [0:255];
  int log_n = 0, wr_count = 0;
  logic pl_en = 0;
  logic [9:0] pl_addr = '0;
  logic [31:0] pl_data = '0;
  logic prev_pend = 0, prev_we = 0, hold_err = 0;
  logic [29:0] prev_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
      mem_ack <= 1'b0; mem_rdata <= '0; prev_pend <= 1'b0;
    end else begin
      if (pl_en) mem[pl_addr] <= pl_data;
      if (prev_pend && (!mem_req || mem_addr != prev_addr || mem_we != prev_we)) hold_err <= 1'b1;
      prev_pend <= mem_req && !mem_ack;
      prev_addr <= mem_addr; prev_we <= mem_we;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        mem_rdata <= mem[mem_addr[9:0]];
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
          wr_count <= wr_count + 1;
        end
        if (log_n < 256) begin lg_addr[log_n] <= mem_addr; lg_we[log_n] <= mem_we; end
        log_n <= log_n + 1;
      end else mem_ack <= 1'b0;
    end
  end

  int n_start = 0, n_end = 0, n_stop = 0, n_eor = 0;
  always @(negedge clk) begin
    if (ev_start) n_start++;
    if (ev_end) n_end++;
    if (ev_stop) n_stop++;
    if (ev_eor) n_eor++;
  end

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic poke(input logic [31:0] byte_addr, input logic [31:0] d);
    pl_en = 1; pl_addr = byte_addr[11:2]; pl_data = d;
    tick(1);
    pl_en = 0;
  endtask

  task automatic put_desc(input logic [31:0] a, nxt, s, t, c);
    poke(a, nxt); poke(a + 4, s); poke(a + 8, t); poke(a + 12, c);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    tick(1);
    cfg_we = 0;
  endtask

  task automatic pulse_go();
    go = 1; tick(1); go = 0;
  endtask

  task automatic wait_idle(input string req);
    int i;
    for (i = 0; i < 3000 && busy; i++) tick(1);
    check(!busy, req, busy, 0);
    tick(2);
  endtask

  task automatic wait_write(input int snap, input string req);
    int i;
    for (i = 0; i < 3000 && wr_count <= snap; i++) tick(1);
    check(wr_count > snap, req, wr_count, snap + 1);
  endtask

  function automatic logic [31:0] mkcmd(input bit is, id, fs, ft, si, ei,
                                        input logic [1:0] bc, wc, input logic [12:0] len);
    return {is, id, fs, ft, 5'b0, si, ei, 3'b0, bc, wc, 1'b0, len};
  endfunction

  task automatic t_reset();
    check(!busy, "R1 busy", busy, 0);
    check(!mem_req, "R1 mem_req", mem_req, 0);
    check({ev_start, ev_end, ev_stop, ev_eor} == 4'b0, "R1 events",
          {ev_start, ev_end, ev_stop, ev_eor}, 0);
  endtask

  task automatic t_chain();
    int b, s0, e0, p0, r0;
    for (int i = 0; i < 5; i++) poke(32'h400 + 4 * i, 32'h1111_0000 + i);
    poke(32'h500, 32'h4433_2211); poke(32'h504, 32'h8877_6655);
    poke(32'h904, 32'hAAAA_AAAA);
    put_desc(32'h100, 32'h140, 32'h400, 32'h800, mkcmd(1, 1, 0, 0, 1, 1, 2'd1, 2'd3, 13'd20));
    put_desc(32'h140, 32'h001, 32'h500, 32'h900, mkcmd(1, 1, 0, 0, 1, 1, 2'd0, 2'd1, 13'd6));
    cfg(2'd0, 32'h100);
    b = log_n; s0 = n_start; e0 = n_end; p0 = n_stop; r0 = n_eor;
    pulse_go();
    wait_idle("R7 chain finishes");
    for (int i = 0; i < 4; i++)
      check(lg_addr[b + i] == 30'h40 + 30'(i) && !lg_we[b + i], "R2 fetch order",
            lg_addr[b + i], 32'h40 + i);
    check(!lg_we[b + 4] && !lg_we[b + 5] && lg_we[b + 6] && lg_we[b + 7],
          "R5 reads before writes", {lg_we[b + 4], lg_we[b + 5], lg_we[b + 6], lg_we[b + 7]}, 4'b0011);
    for (int i = 0; i < 5; i++)
      check(mem[10'h200 + i] == 32'h1111_0000 + i, "R4 word copy", mem[10'h200 + i], 32'h1111_0000 + i);
    check(mem[10'h240] == 32'h4433_2211, "R5 byte copy", mem[10'h240], 32'h4433_2211);
    check(mem[10'h241] == 32'hAAAA_6655, "R5 untouched lanes", mem[10'h241], 32'hAAAA_6655);
    check(n_start - s0 == 2, "R6 start events", n_start - s0, 2);
    check(n_end - e0 == 2, "R6 end events", n_end - e0, 2);
    check(n_stop - p0 == 1, "R7 one stop after chain", n_stop - p0, 1);
    check(n_eor - r0 == 0, "R9 no eor without flow", n_eor - r0, 0);
    check(!hold_err, "R11 fields held until ack", hold_err, 0);
  endtask

  task automatic t_branch();
    int b;
    put_desc(32'h200, 32'h001, 32'h400, 32'hB10, mkcmd(1, 1, 0, 0, 0, 0, 2'd0, 2'd3, 13'd4));
    put_desc(32'h220, 32'h001, 32'h400, 32'hB00, mkcmd(1, 1, 0, 0, 0, 0, 2'd0, 2'd3, 13'd4));
    cfg(2'd0, 32'h20E);
    cmp_flag = 1;
    b = log_n;
    pulse_go();
    wait_idle("R3 branch run ends");
    check(lg_addr[b] == 30'h88, "R3 branch fetch address", lg_addr[b], 32'h88);
    check(mem[10'h2C0] == 32'h1111_0000, "R3 branched descriptor used", mem[10'h2C0], 32'h1111_0000);
    check(mem[10'h2C4] == 32'h0, "R3 base descriptor skipped", mem[10'h2C4], 0);
    cmp_flag = 0;
    cfg(2'd0, 32'h20E);
    b = log_n;
    pulse_go();
    wait_idle("R3 no-branch run ends");
    check(lg_addr[b] == 30'h80, "R2 low pointer bits ignored", lg_addr[b], 32'h80);
    check(mem[10'h2C4] == 32'h1111_0000, "R3 base descriptor used", mem[10'h2C4], 32'h1111_0000);
  endtask

  task automatic t_halfword();
    poke(32'h600, 32'hCAFE_BEEF);
    poke(32'hA00, 32'h1234_5678); poke(32'hA04, 32'h9ABC_DEF0);
    put_desc(32'h300, 32'h001, 32'h600, 32'hA02, mkcmd(0, 1, 0, 0, 0, 0, 2'd0, 2'd2, 13'd6));
    cfg(2'd0, 32'h300);
    pulse_go();
    wait_idle("R4 halfword run ends");
    check(mem[10'h280] == 32'hBEEF_5678, "R4 fixed source, upper half", mem[10'h280], 32'hBEEF_5678);
    check(mem[10'h281] == 32'hBEEF_BEEF, "R5 halfword lanes", mem[10'h281], 32'hBEEF_BEEF);
  endtask

  task automatic t_flow_stop();
    int w0, r0, p0, e0;
    put_desc(32'h340, 32'h001, 32'h603, 32'hC00, mkcmd(0, 1, 1, 0, 0, 1, 2'd0, 2'd3, 13'd12));
    cfg(2'd0, 32'h340);
    eor_stop_en = 1; flow_req = 0;
    r0 = n_eor; p0 = n_stop; e0 = n_end;
    pulse_go();
    tick(30);
    check(busy, "R8 waits for request", busy, 1);
    check(mem[10'h300] == 32'h0, "R8 no write without request", mem[10'h300], 0);
    w0 = wr_count;
    flow_req = 1;
    wait_write(w0, "R8 burst after request");
    flow_req = 0;
    wait_idle("R9 eor stop");
    check(mem[10'h300] == 32'hCAFE_BEEF, "R8 source low bits cleared", mem[10'h300], 32'hCAFE_BEEF);
    check(mem[10'h301] == 32'h0, "R9 no burst after eor", mem[10'h301], 0);
    check(n_eor - r0 == 1, "R9 eor event", n_eor - r0, 1);
    check(n_stop - p0 == 1, "R9 stop on eor", n_stop - p0, 1);
    check(n_end - e0 == 0, "R6 no end before length zero", n_end - e0, 0);
    eor_stop_en = 0;
  endtask

  task automatic t_eor_jump();
    int w0, r0;
    put_desc(32'h380, 32'h3C0, 32'h600, 32'hD00, mkcmd(0, 1, 1, 0, 0, 0, 2'd0, 2'd3, 13'd12));
    put_desc(32'h3C0, 32'h001, 32'h400, 32'hD40, mkcmd(1, 1, 0, 0, 0, 0, 2'd0, 2'd3, 13'd4));
    cfg(2'd0, 32'h380);
    eor_jump_en = 1; flow_req = 0;
    r0 = n_eor;
    pulse_go();
    tick(10);
    w0 = wr_count;
    flow_req = 1;
    wait_write(w0, "R9 first burst");
    flow_req = 0;
    wait_idle("R9 jump chain ends");
    check(mem[10'h340] == 32'hCAFE_BEEF, "R9 burst before eor", mem[10'h340], 32'hCAFE_BEEF);
    check(mem[10'h341] == 32'h0, "R9 rest abandoned", mem[10'h341], 0);
    check(mem[10'h350] == 32'h1111_0000, "R9 jumped descriptor ran", mem[10'h350], 32'h1111_0000);
    check(n_eor - r0 == 1, "R9 eor event on jump", n_eor - r0, 1);
    eor_jump_en = 0;
  endtask

  task automatic t_regs();
    int p0;
    nofetch = 1;
    cfg(2'd1, 32'h400); cfg(2'd2, 32'hE00);
    cfg(2'd3, mkcmd(1, 1, 0, 0, 0, 0, 2'd0, 2'd3, 13'd8));
    p0 = n_stop;
    pulse_go();
    wait_idle("R10 register run ends");
    check(mem[10'h380] == 32'h1111_0000 && mem[10'h381] == 32'h1111_0001,
          "R10 idle writes used", mem[10'h381], 32'h1111_0001);
    check(n_stop - p0 == 1, "R7 nofetch stops at zero", n_stop - p0, 1);
    cfg(2'd1, 32'h600); cfg(2'd2, 32'hE10);
    cfg(2'd3, mkcmd(0, 1, 1, 0, 0, 0, 2'd0, 2'd3, 13'd4));
    flow_req = 0;
    pulse_go();
    tick(5);
    cfg(2'd2, 32'hE20);
    flow_req = 1;
    wait_idle("R10 second run ends");
    flow_req = 0;
    check(mem[10'h384] == 32'hCAFE_BEEF, "R10 original target kept", mem[10'h384], 32'hCAFE_BEEF);
    check(mem[10'h388] == 32'h0, "R10 busy write ignored", mem[10'h388], 0);
    nofetch = 0;
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1;
    tick(2);
    t_chain();
    t_branch();
    t_halfword();
    t_flow_stop();
    t_eor_jump();
    t_regs();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end
endmodule